// File: doc/BRIEF.md
# Pin-Coded Voltage Select and Enable

This block turns four slow, asynchronous control pins into the enable, the output-voltage setpoint and the soft-start trigger of a step-down converter. There is no separate enable pin: the all-low code means shutdown, and each of the fifteen other codes both turns the converter on and picks its target voltage. Each pin is brought into the clock domain through a synchronizer. A new nonzero code is then accepted only after it has held steady for a programmable number of samples. A single all-low sample is never filtered and shuts the converter down at once, because a code change that passes through zero must disable the part.

The block also drives one weak pull-down enable per pin. Every pull-down is on after power-on reset. A pin's pull-down is released as soon as that pin is sampled high. It stays released, even if the pin later goes low, until all four pins are sampled low together. Each rising edge of the enable produces a one-clock start pulse for the soft-start sequencer. The voltage setpoint is reported in millivolts.

All inputs and outputs are plain level signals that are sampled or updated on every clock; there is no streaming data path.

Top module: `ctlpin_enable_ctrl`

## Requirements
- R1: While `rst_n` is low, `conv_en_o` is 0, `start_pulse_o` is 0, `vout_mv_o` is 0 and `pulldown_en_o` is 4'b1111.
- R2: With code c = `ctl_pin_i` (bit 3 most significant) accepted, `vout_mv_o` reads 800, 1000, 1100, 1200, 1350, 1500, 1600, 1800, 2000, 2500, 2800, 3000, 3300, 3400, 3600 for c = 1 through 15 in ascending order, and reads 0 for c = 0.
- R3: `conv_en_o` is 1 exactly when the accepted code is nonzero.
- R4: A nonzero code is accepted only after FILT_LEN consecutive equal synchronized samples. A pin change held steady reaches `vout_mv_o` on the (FILT_LEN+4)-th rising edge after the change, and not before. A nonzero excursion held for one cycle leaves `vout_mv_o` unchanged.
- R5: One synchronized all-low sample is enough to clear the accepted code. `conv_en_o` falls on the 4th rising edge after the pins go low, and this holds even when the low code lasts a single clock.
- R6: `start_pulse_o` is high for exactly one clock, in the cycle where `conv_en_o` first reads 1 after having read 0, and is low at all other times.
- R7: `pulldown_en_o[i]` goes to 0 once `ctl_pin_i[i]` is sampled high. It then stays 0 while any pin is high, even after pin i returns low.
- R8: All four pull-down enables return to 1 together, and only when all pins are sampled low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ctl_pin_i | input | 4 | Asynchronous control pins; code with bit 3 as MSB |
| conv_en_o | output | 1 | Converter enable |
| pulldown_en_o | output | 4 | Per-pin weak pull-down enable (1 = pull-down on) |
| vout_mv_o | output | 12 | Selected output voltage in millivolts, 0 in shutdown |
| start_pulse_o | output | 1 | One-clock soft-start trigger on each enable rising edge |

## Verification
The hardest case to reach is a code change that dips through all-low for a single clock between two nonzero codes. The dip must re-trigger start-up, while an equally short nonzero excursion must be filtered out. The stimulus drives the pins on falling clock edges, so a one-period pulse turns into exactly one synchronized sample. The bench then counts enable-low cycles and start pulses over a long settling window. The same counters, watched during a one-cycle nonzero excursion, confirm that the setpoint never moves and no start pulse appears.

// File: rtl/ctlpin_pkg.sv
package ctlpin_pkg;
  localparam int CODE_W = 4;
  localparam int MV_W   = 12;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [MV_W-1:0]   mv_t;

  function automatic mv_t code_to_mv(input code_t c);
    mv_t r;
    case (c)
      4'd1:    r = 12'd800;
      4'd2:    r = 12'd1000;
      4'd3:    r = 12'd1100;
      4'd4:    r = 12'd1200;
      4'd5:    r = 12'd1350;
      4'd6:    r = 12'd1500;
      4'd7:    r = 12'd1600;
      4'd8:    r = 12'd1800;
      4'd9:    r = 12'd2000;
      4'd10:   r = 12'd2500;
      4'd11:   r = 12'd2800;
      4'd12:   r = 12'd3000;
      4'd13:   r = 12'd3300;
      4'd14:   r = 12'd3400;
      4'd15:   r = 12'd3600;
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ctlpin_sync.sv
module ctlpin_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/ctlpin_filter.sv
module ctlpin_filter
  import ctlpin_pkg::*;
#(
  parameter int FILT_LEN = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  code_t code_i,
  output code_t code_o
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FILT_LEN - 1);

  code_t            cand_q;
  code_t            acc_q;
  logic [CNT_W-1:0] cnt_q;

  // Zero bypasses the filter; nonzero codes must be stable for FILT_LEN samples.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
    end else if (code_i == '0) begin
      cand_q <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
    end else if (code_i != cand_q) begin
      cand_q <= code_i;
      cnt_q  <= '0;
    end else if (cnt_q == CNT_MAX) begin
      acc_q  <= cand_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign code_o = acc_q;
endmodule

// File: rtl/ctlpin_pulldown.sv
module ctlpin_pulldown #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_sync_i,
  output logic [WIDTH-1:0] pd_en_o
);
  logic             all_low;
  logic [WIDTH-1:0] released_q;

  assign all_low = (pin_sync_i == '0);

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       released_q[i] <= 1'b0;
        else if (all_low) released_q[i] <= 1'b0;
        else if (pin_sync_i[i]) released_q[i] <= 1'b1;
      end
    end
  endgenerate

  assign pd_en_o = ~released_q;
endmodule

// File: rtl/ctlpin_outreg.sv
module ctlpin_outreg
  import ctlpin_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  code_t code_i,
  output logic  en_o,
  output logic  start_o,
  output mv_t   mv_o
);
  logic en_d;
  assign en_d = (code_i != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o    <= 1'b0;
      start_o <= 1'b0;
      mv_o    <= '0;
    end else begin
      en_o    <= en_d;
      start_o <= en_d & ~en_o;
      mv_o    <= code_to_mv(code_i);
    end
  end
endmodule

// File: rtl/ctlpin_enable_ctrl.sv
module ctlpin_enable_ctrl
  import ctlpin_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  ctl_pin_i,
  output logic        conv_en_o,
  output logic [3:0]  pulldown_en_o,
  output logic [11:0] vout_mv_o,
  output logic        start_pulse_o
);
  code_t pin_sync;
  code_t code_acc;

  ctlpin_sync #(.WIDTH(CODE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ctl_pin_i), .sync_o(pin_sync)
  );

  ctlpin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n), .code_i(pin_sync), .code_o(code_acc)
  );

  ctlpin_pulldown #(.WIDTH(CODE_W)) u_pd (
    .clk(clk), .rst_n(rst_n), .pin_sync_i(pin_sync), .pd_en_o(pulldown_en_o)
  );

  ctlpin_outreg u_out (
    .clk(clk), .rst_n(rst_n), .code_i(code_acc),
    .en_o(conv_en_o), .start_o(start_pulse_o), .mv_o(vout_mv_o)
  );
endmodule

// File: rtl/ctlpin_checker.sv
module ctlpin_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        conv_en_o,
  input logic [3:0]  pulldown_en_o,
  input logic [11:0] vout_mv_o,
  input logic        start_pulse_o
);
  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_STATE: assert (pulldown_en_o == 4'hF && !conv_en_o && !start_pulse_o); // R1
    end
  end

  AST_EN_MATCHES_MV: assert property (@(posedge clk) disable iff (!rst_n)
    conv_en_o == (vout_mv_o != 12'd0)); // R3

  AST_MV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_en_o |-> (vout_mv_o >= 12'd800 && vout_mv_o <= 12'd3600)); // R2

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse_o |=> !start_pulse_o); // R6

  AST_START_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse_o |-> (conv_en_o && !$past(conv_en_o))); // R6

  AST_PD_REARM_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pulldown_en_o & ~$past(pulldown_en_o))) |-> (pulldown_en_o == 4'hF)); // R8
endmodule

bind ctlpin_enable_ctrl ctlpin_checker u_chk (
  .clk(clk), .rst_n(rst_n), .conv_en_o(conv_en_o),
  .pulldown_en_o(pulldown_en_o), .vout_mv_o(vout_mv_o),
  .start_pulse_o(start_pulse_o)
);

// File: tb/sim_ctlpin_enable_ctrl.sv
`timescale 1ns/1ps
module sim_ctlpin_enable_ctrl;
  localparam int FILT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  pins = 4'h0;
  logic        en;
  logic [3:0]  pd;
  logic [11:0] mv;
  logic        start;

  int checks = 0;
  int errors = 0;
  int starts = 0;
  int en_low = 0;
  int mv_off = 0;
  logic [11:0] mv_ref = 12'd0;
  bit done = 0;

  always #10 clk = ~clk;

  ctlpin_enable_ctrl #(.FILT_LEN(FILT)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_pin_i(pins), .conv_en_o(en),
    .pulldown_en_o(pd), .vout_mv_o(mv), .start_pulse_o(start)
  );

  always @(negedge clk) begin
    if (rst_n && start) starts++;
    if (rst_n && !en) en_low++;
    if (rst_n && mv != mv_ref) mv_off++;
  end

  // code in [15:12], expected millivolts in [11:0]
  localparam logic [15:0] VEC [15] = '{
    {4'd1, 12'd800},  {4'd2, 12'd1000}, {4'd3, 12'd1100}, {4'd4, 12'd1200},
    {4'd5, 12'd1350}, {4'd6, 12'd1500}, {4'd7, 12'd1600}, {4'd8, 12'd1800},
    {4'd9, 12'd2000}, {4'd10, 12'd2500}, {4'd11, 12'd2800}, {4'd12, 12'd3000},
    {4'd13, 12'd3300}, {4'd14, 12'd3400}, {4'd15, 12'd3600}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] v);
    @(negedge clk);
    pins = v;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int s0;
    edges(3);
    // R1: reset state
    chk("R1 en", en, 0);
    chk("R1 pd", pd, 15);
    chk("R1 mv", mv, 0);
    chk("R1 start", start, 0);
    drive(4'h0);
    rst_n = 1'b1;
    edges(5);
    chk("R3 en idle", en, 0);

    // R2/R3: walk every code without passing through zero
    for (int k = 0; k < 15; k++) begin
      drive(VEC[k][15:12]);
      edges(FILT + 6);
      chk("R2 mv", mv, int'(VEC[k][11:0]));
      chk("R3 en", en, 1);
    end
    chk("R6 one start after walk", starts, 1);

    // R4: acceptance latency, code 8 -> 9
    drive(4'd8);
    edges(FILT + 6);
    drive(4'd9);
    edges(FILT + 3);
    chk("R4 mv before latency", mv, 1800);
    edges(1);
    chk("R4 mv at latency", mv, 2000);

    // R5: all-low latency
    drive(4'd8);
    edges(FILT + 6);
    drive(4'd0);
    edges(3);
    chk("R5 en before fall", en, 1);
    edges(1);
    chk("R5 en fallen", en, 0);
    chk("R8 pd all on", pd, 15);

    // R5/R6: single-cycle dip through zero re-triggers start
    drive(4'd8);
    edges(FILT + 6);
    s0 = starts;
    en_low = 0;
    drive(4'd0);
    drive(4'd8);
    edges(FILT + 10);
    chk("R5 en low seen", (en_low > 0) ? 1 : 0, 1);
    chk("R6 one restart", starts - s0, 1);
    chk("R2 mv restored", mv, 1800);

    // R4: one-cycle nonzero excursion ignored
    s0 = starts;
    mv_ref = 12'd1800;
    mv_off = 0;
    drive(4'd9);
    drive(4'd8);
    edges(FILT + 10);
    chk("R4 mv unchanged", mv_off, 0);
    chk("R6 no start", starts - s0, 0);
    mv_ref = 12'd0;

    // R7/R8: pull-down release and hold
    drive(4'd0);
    edges(6);
    drive(4'b0100);
    edges(4);
    chk("R7 pin2 released", pd, 4'b1011);
    drive(4'b0101);
    edges(4);
    chk("R7 pin0 released", pd, 4'b1010);
    drive(4'b0001);
    edges(FILT + 6);
    chk("R7 pin2 held released", pd, 4'b1010);
    drive(4'b0000);
    edges(4);
    chk("R8 all rearmed", pd, 4'b1111);

    // R1/R6: reset while enabled, then restart
    drive(4'd12);
    edges(FILT + 6);
    s0 = starts;
    @(negedge clk);
    rst_n = 1'b0;
    #5;
    chk("R1 en in reset", en, 0);
    chk("R1 pd in reset", pd, 15);
    @(negedge clk);
    rst_n = 1'b1;
    edges(FILT + 8);
    chk("R6 start after reset", starts - s0, 1);
    chk("R2 mv after reset", mv, 3000);

    finish_run();
  end
endmodule